// File: doc/BRIEF.md
# Dual-Role Serial Byte Port

This block is an 8-bit synchronous serial port that can run as the clock-owning side of a link or as a follower clocked from outside. Software reaches it through three byte-wide registers, chosen by a 2-bit select: configuration, status and data. One internal shift register carries traffic in both directions. Each finished byte is copied into a separate receive buffer, and reads of the data register return that buffer.

In the clock-owning role, a write to the data register starts a burst of eight serial clocks. The rate is derived from the bus clock, and the written byte goes out most significant bit first while the incoming line is shifted in. In the follower role the port moves bits only while the select input is low, and it uses edges of the external serial clock, brought into the bus clock domain through a two-stage synchronizer. A byte written beforehand waits in the shift register until the remote side clocks it out. A completion flag and a gated interrupt report finished bytes. A write that arrives during a shift is refused and flagged. Each pin has an output enable, and an open-drain option lets those enables emulate a pull-down-only driver.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x04, status reads 0x00, the data register reads 0x00, `irq` is 0, and `sck_out` and `sck_oe` are 0.
- R2: With enable (bit 6) and clock-owner (bit 4) set, `sck_out` rests at the clock-polarity bit (bit 3) while idle. A data-register write then produces exactly 16 `sck_out` transitions, after which `sck_out` is back at the polarity level.
- R3: In the clock-owning role, the rate field (bits 1:0) sets the spacing of adjacent `sck_out` transitions to 1, 2, 8 or 16 bus clocks for codes 0, 1, 2 and 3.
- R4: Bits move most significant first. With the phase bit (bit 2) at 0, the outgoing line holds a bit on each leading (away-from-idle) clock edge and the incoming line is sampled on that edge, with the first bit valid before the first edge. With the phase bit at 1, the outgoing line changes on leading edges and the incoming line is sampled on trailing edges.
- R5: When the eighth bit has been sampled, the received byte is copied into the receive buffer, and data-register reads (select 2) return it.
- R6: In the follower role (bit 4 clear), shifting happens only on `sck_in` edges while `ss_n_in` is low, with input from `mosi_in` and the written byte sent on `miso_out`. Clock edges while `ss_n_in` is high neither shift nor complete a byte.
- R7: Status bit 7 is set when a byte completes. It is cleared only by a status read (select 1) made while the flag is set, followed by a data-register read or write. A data access with no status read before it leaves the flag set.
- R8: `irq` is 1 exactly while status bit 7 and the interrupt-enable bit (bit 7 of configuration) are both set.
- R9: A data-register write during a byte sets status bit 6 and does not change the byte being shifted. Bit 6 is cleared by the same sequence as bit 7.
- R10: The clock owner enables `sck_oe` and `mosi_oe`, and `miso_oe` stays 0. A follower enables only `miso_oe`, and only while `ss_n_in` is low. With the open-drain bit (bit 5) set, each enable is asserted only while its pin drives 0.
- R11: Configuration writes (select 0) read back unchanged, and select 3 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 configuration, 1 status, 2 data, 3 unused |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; needed for the status-then-data clear sequence |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Completion interrupt |
| sck_in | input | 1 | Serial clock from the pin (follower role) |
| sck_out | output | 1 | Serial clock to the pin (clock-owning role) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_in | input | 1 | Owner-to-follower line from the pin (follower input) |
| mosi_out | output | 1 | Owner-to-follower line driven by the clock owner |
| mosi_oe | output | 1 | Owner-to-follower output enable |
| miso_in | input | 1 | Follower-to-owner line from the pin (owner input) |
| miso_out | output | 1 | Follower-to-owner line driven by the follower |
| miso_oe | output | 1 | Follower-to-owner output enable |
| ss_n_in | input | 1 | Active-low select for the follower role |

## Verification
The hardest state to reach from the ports is a write collision inside a burst, paired with the two-step flag clear. Neither can happen unless a byte is in flight and the register accesses come in a set order. The bench injects a data write two cycles into a slow burst, checks the remote model's captured byte against the original, then walks the status-read and data-access sequence, including a data read that is not preceded by a status read. The follower's select gating is exercised by toggling `sck_in` while `ss_n_in` is high, then running a real byte and checking that it arrives aligned.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;

    localparam int DATA_W = 8;
    localparam int DIV_W  = 4;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       ie;
        logic       en;
        logic       od;
        logic       mst;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{ie: 1'b0, en: 1'b0, od: 1'b0, mst: 1'b0,
                                     cpol: 1'b0, cpha: 1'b1, rate: 2'b00};

    // Bus clocks per half serial period, minus one
    function automatic logic [DIV_W-1:0] half_minus1(input logic [1:0] rate);
        case (rate)
            2'd0:    return DIV_W'(0);
            2'd1:    return DIV_W'(1);
            2'd2:    return DIV_W'(7);
            default: return DIV_W'(15);
        endcase
    endfunction

endpackage

// File: rtl/spi_port_clkgen.sv
`timescale 1ns/1ps
module spi_port_clkgen #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [DIV_W-1:0] half_m1,
    output logic             busy,
    output logic             phase,
    output logic             lead,
    output logic             trail
);
    localparam int EDGES  = 2 * DATA_W;
    localparam int EDGE_W = $clog2(EDGES);

    logic [DIV_W-1:0]  div_q;
    logic [EDGE_W-1:0] edge_q;
    logic              tick;

    assign tick  = busy && (div_q == half_m1);
    assign lead  = tick && !phase;
    assign trail = tick && phase;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy   <= 1'b0;
            phase  <= 1'b0;
            div_q  <= '0;
            edge_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                phase  <= 1'b0;
                div_q  <= '0;
                edge_q <= '0;
            end
        end else if (tick) begin
            div_q  <= '0;
            phase  <= ~phase;
            edge_q <= edge_q + 1'b1;
            if (edge_q == EDGE_W'(EDGES - 1)) begin
                busy <= 1'b0;
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_port_shifter.sv
`timescale 1ns/1ps
module spi_port_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              cpha,
    input  logic              lead,
    input  logic              trail,
    input  logic              clr,
    input  logic              sin,
    output logic              out_bit,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done,
    output logic              mid
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sample;
    logic              drive;

    assign sample = cpha ? trail : lead;
    assign drive  = cpha ? lead  : trail;
    assign done   = sample && !load && !clr && (cnt_q == CNT_W'(DATA_W - 1));
    assign mid    = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q    <= '0;
            cnt_q   <= '0;
            out_bit <= 1'b0;
            rx_byte <= '0;
        end else if (load) begin
            sr_q  <= load_data;
            cnt_q <= '0;
            if (!cpha) begin
                out_bit <= load_data[DATA_W-1];
            end
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            if (sample) begin
                sr_q  <= {sr_q[DATA_W-2:0], sin};
                cnt_q <= done ? '0 : cnt_q + 1'b1;
                if (done) begin
                    rx_byte <= {sr_q[DATA_W-2:0], sin};
                end
            end
            if (drive) begin
                out_bit <= sr_q[DATA_W-1];
            end
        end
    end
endmodule

// File: rtl/spi_port_regs.sv
`timescale 1ns/1ps
module spi_port_regs
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic              busy,
    input  logic [DATA_W-1:0] rx_byte,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              load,
    output logic              flag,
    output logic              wcol
);
    logic data_wr, data_rd, stat_rd, collide, clear, armed;

    assign data_wr = wr && (sel == SEL_DATA);
    assign data_rd = rd && (sel == SEL_DATA);
    assign stat_rd = rd && (sel == SEL_STAT);
    assign load    = data_wr && !busy;
    assign collide = data_wr && busy;
    assign clear   = (data_wr || data_rd) && armed;
    assign irq     = ctrl.ie && flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= CTRL_RESET;
            flag  <= 1'b0;
            wcol  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (wr && (sel == SEL_CTRL)) begin
                ctrl <= ctrl_t'(wdata);
            end
            if (stat_rd && (flag || wcol)) begin
                armed <= 1'b1;
            end else if (data_wr || data_rd) begin
                armed <= 1'b0;
            end
            if (done) begin
                flag <= 1'b1;
            end else if (clear) begin
                flag <= 1'b0;
            end
            if (collide) begin
                wcol <= 1'b1;
            end else if (clear) begin
                wcol <= 1'b0;
            end
        end
    end

    always_comb begin
        case (reg_sel_e'(sel))
            SEL_CTRL: rdata = ctrl;
            SEL_STAT: rdata = {flag, wcol, {(DATA_W-2){1'b0}}};
            SEL_DATA: rdata = rx_byte;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_port_ctrl.sv
`timescale 1ns/1ps
module spi_port_ctrl
    import spi_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    input  logic              miso_in,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic              ss_n_in
);
    ctrl_t             ctrl;
    logic              m_busy, m_phase, m_lead, m_trail;
    logic              s_lead, s_trail, s_active;
    logic              sh_lead, sh_trail, sh_done, sh_mid, sh_clr, sh_out;
    logic [DATA_W-1:0] rx_byte;
    logic              st_flag, st_wcol, ld;
    logic              own, follow;

    // Pin synchronizers for the follower role
    logic [SYNC_STAGES-1:0] sck_sy;
    logic [SYNC_STAGES-1:0] ss_sy;
    logic                   sck_prev;
    logic                   sck_s, ss_s, s_rise, s_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sy   <= '0;
            ss_sy    <= '1;
            sck_prev <= 1'b0;
        end else begin
            sck_sy   <= {sck_sy[SYNC_STAGES-2:0], sck_in};
            ss_sy    <= {ss_sy[SYNC_STAGES-2:0], ss_n_in};
            sck_prev <= sck_s;
        end
    end

    assign sck_s    = sck_sy[SYNC_STAGES-1];
    assign ss_s     = ss_sy[SYNC_STAGES-1];
    assign s_rise   = sck_s && !sck_prev;
    assign s_fall   = !sck_s && sck_prev;
    assign own      = ctrl.en && ctrl.mst;
    assign follow   = ctrl.en && !ctrl.mst;
    assign s_active = follow && !ss_s;
    assign s_lead   = s_active && (ctrl.cpol ? s_fall : s_rise);
    assign s_trail  = s_active && (ctrl.cpol ? s_rise : s_fall);

    spi_port_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel     (reg_sel),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .wdata   (reg_wdata),
        .done    (sh_done),
        .busy    (m_busy || sh_mid),
        .rx_byte (rx_byte),
        .ctrl    (ctrl),
        .rdata   (reg_rdata),
        .irq     (irq),
        .load    (ld),
        .flag    (st_flag),
        .wcol    (st_wcol)
    );

    spi_port_clkgen #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .start   (ld && own),
        .abort   (!own),
        .half_m1 (half_minus1(ctrl.rate)),
        .busy    (m_busy),
        .phase   (m_phase),
        .lead    (m_lead),
        .trail   (m_trail)
    );

    assign sh_lead  = ctrl.mst ? m_lead  : s_lead;
    assign sh_trail = ctrl.mst ? m_trail : s_trail;
    assign sh_clr   = !ctrl.en || (!ctrl.mst && ss_s);

    spi_port_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (ld),
        .load_data (reg_wdata),
        .cpha      (ctrl.cpha),
        .lead      (sh_lead),
        .trail     (sh_trail),
        .clr       (sh_clr),
        .sin       (ctrl.mst ? miso_in : mosi_in),
        .out_bit   (sh_out),
        .rx_byte   (rx_byte),
        .done      (sh_done),
        .mid       (sh_mid)
    );

    // Pins; open-drain emulation releases the enable while driving 1
    assign sck_out  = ctrl.cpol ^ m_phase;
    assign mosi_out = sh_out;
    assign miso_out = sh_out;
    assign sck_oe   = own && (!ctrl.od || !sck_out);
    assign mosi_oe  = own && (!ctrl.od || !sh_out);
    assign miso_oe  = s_active && (!ctrl.od || !sh_out);

    logic unused_wcol;
    assign unused_wcol = st_wcol;
endmodule

// File: rtl/spi_port_ctrl_chk.sv
`timescale 1ns/1ps
module spi_port_ctrl_chk
    import spi_port_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input ctrl_t ctrl,
    input logic  m_busy,
    input logic  sh_mid,
    input logic  sh_done,
    input logic  st_flag,
    input logic  ld,
    input logic  sck_out,
    input logic  sck_oe,
    input logic  miso_oe
);
    localparam int LIMIT = 2 * DATA_W * 16;

    logic [15:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (rst || !m_busy) busy_cnt <= '0;
        else                busy_cnt <= busy_cnt + 1'b1;
    end

    AST_SCK_RESTS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && ctrl.mst && !m_busy) |-> (sck_out == ctrl.cpol)); // R2

    AST_BURST_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        m_busy |-> (busy_cnt < 16'(LIMIT))); // R3

    AST_FLAG_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(st_flag) |-> $past(sh_done)); // R7

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        ld |-> !(m_busy || sh_mid)); // R9

    AST_ONE_CLOCK_SIDE: assert property (@(posedge clk) disable iff (rst)
        !(sck_oe && miso_oe)); // R10

    AST_FOLLOWER_NO_SCK: assert property (@(posedge clk) disable iff (rst)
        !ctrl.mst |-> !sck_oe); // R10
endmodule

bind spi_port_ctrl spi_port_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .m_busy  (m_busy),
    .sh_mid  (sh_mid),
    .sh_done (sh_done),
    .st_flag (st_flag),
    .ld      (ld),
    .sck_out (sck_out),
    .sck_oe  (sck_oe),
    .miso_oe (miso_oe)
);

// File: tb/tb_spi_port_ctrl.sv
`timescale 1ns/1ps
module tb_spi_port_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       sck_in = 1'b0, mosi_in = 1'b0, miso_in = 1'b0, ss_n_in = 1'b1;
    logic       sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;

    int checks = 0;
    int fails  = 0;
    int wd     = 0;

    always #2.5 clk = ~clk;

    spi_port_ctrl dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
        .ss_n_in(ss_n_in)
    );

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            $display("FAIL watchdog expired actual=%0d expected<150000", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic int half_of(input logic [1:0] r);
        return (r == 2'd0) ? 1 : (r == 2'd1) ? 2 : (r == 2'd2) ? 8 : 16;
    endfunction

    task automatic master_xfer(input logic cpol, input logic cpha, input logic [1:0] rate,
                               input logic [7:0] tx, input logic [7:0] stx,
                               input logic ie, input logic inject);
        int half, edges, cyc, last, bad_gap, sidx;
        logic prev;
        logic [7:0] cap, rd;
        half = half_of(rate);
        reg_write(2'd0, {ie, 1'b1, 1'b0, 1'b1, cpol, cpha, rate});
        sidx = 0;
        miso_in = cpha ? 1'b0 : stx[7];
        wait_clk(1);
        chk("R2 idle level before burst", sck_out, cpol);
        chk("R10 owner drives sck", sck_oe, 1'b1);
        reg_write(2'd2, tx);
        edges = 0; cyc = 0; last = 0; bad_gap = 0; prev = sck_out; cap = 8'h00;
        for (int k = 0; k < 16 * half + 6; k++) begin
            @(negedge clk);
            cyc++;
            if (inject && k == 2) begin reg_sel = 2'd2; reg_wdata = ~tx; reg_wr = 1'b1; end
            if (inject && k == 3) reg_wr = 1'b0;
            if (sck_out != prev) begin
                edges++;
                if (cyc - last != half) bad_gap++;
                last = cyc;
                prev = sck_out;
                if (sck_out != cpol) begin
                    if (!cpha) cap = {cap[6:0], mosi_out};
                    else begin
                        miso_in = (sidx < 8) ? stx[7 - sidx] : 1'b0;
                        sidx++;
                    end
                end else begin
                    if (!cpha) begin
                        sidx++;
                        miso_in = (sidx < 8) ? stx[7 - sidx] : 1'b0;
                    end else cap = {cap[6:0], mosi_out};
                end
            end
        end
        chk("R2 sixteen clock transitions", edges, 16);
        chk("R3 transition spacing", bad_gap, 0);
        chk("R2 idle level after burst", sck_out, cpol);
        chk(inject ? "R9 byte undisturbed by collision" : "R4 bits sent msb first", cap, tx);
        chk("R8 irq follows flag and enable", irq, ie);
        reg_read(2'd1, rd);
        chk("R7 R9 status after byte", rd, inject ? 8'hC0 : 8'h80);
        reg_read(2'd2, rd);
        chk("R5 R4 received byte", rd, stx);
        reg_read(2'd1, rd);
        chk("R7 status cleared", rd, 8'h00);
        chk("R8 irq drops", irq, 1'b0);
    endtask

    task automatic slave_xfer(input logic cpol, input logic cpha,
                              input logic [7:0] tx, input logic [7:0] mtx);
        logic [7:0] cap, rd;
        reg_write(2'd0, {1'b0, 1'b1, 1'b0, 1'b0, cpol, cpha, 2'b00});
        reg_write(2'd2, tx);
        sck_in = cpol;
        wait_clk(4);
        ss_n_in = 1'b0;
        wait_clk(4);
        chk("R10 follower drives miso while selected", miso_oe, 1'b1);
        chk("R10 follower leaves sck", sck_oe, 1'b0);
        cap = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            if (!cpha) begin
                mosi_in = mtx[i];
                wait_clk(8);
                sck_in = ~cpol;
                wait_clk(8);
                cap = {cap[6:0], miso_out};
                sck_in = cpol;
                wait_clk(8);
            end else begin
                sck_in = ~cpol;
                wait_clk(8);
                mosi_in = mtx[i];
                cap = {cap[6:0], miso_out};
                sck_in = cpol;
                wait_clk(8);
            end
        end
        wait_clk(6);
        ss_n_in = 1'b1;
        wait_clk(4);
        chk("R10 follower releases miso when deselected", miso_oe, 1'b0);
        chk("R6 follower sends written byte", cap, tx);
        reg_read(2'd1, rd);
        chk("R7 follower completion flag", rd, 8'h80);
        reg_read(2'd2, rd);
        chk("R5 R6 follower received byte", rd, mtx);
    endtask

    initial begin
        logic [7:0] rd;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(1);
        // R1 reset state
        reg_read(2'd0, rd); chk("R1 config reset", rd, 8'h04);
        reg_read(2'd1, rd); chk("R1 status reset", rd, 8'h00);
        reg_read(2'd2, rd); chk("R1 data reset", rd, 8'h00);
        chk("R1 irq reset", irq, 1'b0);
        chk("R1 sck reset", {sck_out, sck_oe}, 2'b00);
        // R11 map
        reg_write(2'd0, 8'h8B); reg_read(2'd0, rd); chk("R11 config readback", rd, 8'h8B);
        reg_read(2'd3, rd); chk("R11 unused select", rd, 8'h00);

        // Clock-owner sweep over every phase, polarity and rate
        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int k = 0; k < 2; k++) begin
                logic [7:0] tx, stx;
                tx  = 8'(k * 73 + cfg * 29 + 5);
                stx = ~tx ^ 8'(cfg * 3);
                master_xfer(cfg[3], cfg[2], cfg[1:0], tx, stx, 1'(k), 1'b0);
            end
        end

        // R9 collision mid-burst at the slowest rate
        master_xfer(1'b0, 1'b1, 2'd3, 8'hB4, 8'h3C, 1'b1, 1'b1);

        // R7 data access without prior status read keeps the flag
        master_xfer(1'b1, 1'b0, 2'd0, 8'h11, 8'h22, 1'b0, 1'b0);
        reg_write(2'd2, 8'h96);
        wait_clk(24);
        reg_read(2'd2, rd);
        reg_read(2'd1, rd); chk("R7 flag kept without status read", rd, 8'h80);
        reg_read(2'd2, rd); chk("R5 second byte buffered", rd, 8'h00);
        reg_read(2'd1, rd); chk("R7 flag cleared by sequence", rd, 8'h00);

        // R10 open-drain emulation on the clock pin
        reg_write(2'd0, 8'h78); wait_clk(1);
        chk("R10 open drain releases high sck", sck_oe, 1'b0);
        reg_write(2'd0, 8'h70); wait_clk(1);
        chk("R10 open drain drives low sck", sck_oe, 1'b1);
        chk("R10 owner keeps miso released", miso_oe, 1'b0);

        // Follower: edges while deselected are ignored
        reg_write(2'd0, 8'h40);
        for (int j = 0; j < 16; j++) begin
            sck_in = ~sck_in; mosi_in = j[0]; wait_clk(6);
        end
        sck_in = 1'b0;
        wait_clk(4);
        reg_read(2'd1, rd); chk("R6 deselected edges do not complete", rd, 8'h00);
        chk("R10 deselected follower releases miso", miso_oe, 1'b0);

        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 2; k++) begin
                slave_xfer(m[1], m[0], 8'(m * 53 + k * 91 + 7), 8'(m * 17 + k * 101 + 66));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule